// File: doc/BRIEF.md
# Associative Virtual Page Translator

This block turns a 32-bit virtual address into a physical address by looking up its page number in a content-addressable table. The low 10 bits are the byte offset inside a 1024-byte page. The upper 22 bits form the virtual page number. Each table entry holds a 22-bit tag, a 14-bit physical page number and a valid bit. In a lookup, the registered page number is compared against every entry at once. A hit flag and the joined physical address come out one cycle later.

Software fills the table through the same pins that carry translations. A mode input selects translate or load.

- In load mode the index bus names the entry and the field select picks the physical-page field or the tag field.
- A write happens only on a rising edge of a write strobe.
- Every tag or page value is taken from the address bus.

The bidirectional pins of a classic part are split here into separate inputs, outputs and output enables. Fault servicing and victim choice belong to the surrounding system.

Top module: `vpage_xlate`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid and `hit_out` is 0. `pa_out` reads 0 and `pa_oe` is low until enabled.
- R2: The virtual address splits into an offset (bits 9:0) and a page number (bits 31:10). The offset is copied unchanged into `pa_out[9:0]`.
- R3: An address sampled in translate mode at clock edge k is reflected on `hit_out` and `pa_out` from edge k+1. Between k and k+1 the outputs keep the previous result.
- R4: `hit_out` is 1 when a valid entry's tag equals the page number. `pa_out[23:10]` then carries that entry's physical page. `hit_oe` equals `xlate_mode`.
- R5: When no valid entry matches, `hit_out` is 0 and `pa_out[23:10]` is 0.
- R6: When several valid entries match, the entry with the lowest index supplies the physical page.
- R7: `pa_oe` is high only when `xlate_mode` and `pa_en` are both 1. Otherwise `pa_out` is 0.
- R8: In load mode (`xlate_mode`=0), the entry addressed by `idx_bus` is written as follows:
  - `field_sel`=0 writes the physical page from `a_bus[13:0]`.
  - `field_sel`=1 writes the tag from `a_bus[31:10]` and marks the entry valid.
- R9: A write happens only on a 0-to-1 transition of `wr_strobe`. Changes of `a_bus` while the strobe stays high are not written.
- R10: A strobe rising edge in translate mode writes nothing.
- R11: In load mode `hit_out` keeps the value of the last translation.
- R12: Writing only the physical-page field of an entry does not make it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlate_mode | input | 1 | 1 = translate, 0 = load |
| a_bus | input | 32 | Virtual address, or load data |
| idx_bus | input | 8 | Entry index in load mode |
| field_sel | input | 1 | Load field: 0 physical page, 1 tag |
| wr_strobe | input | 1 | Write strobe, acts on its rising edge |
| pa_en | input | 1 | Physical address output enable |
| hit_out | output | 1 | Registered hit flag |
| hit_oe | output | 1 | Hit flag drive enable |
| pa_out | output | 24 | Physical address {page, offset} |
| pa_oe | output | 1 | Physical address drive enable |

## Verification
The bench builds the translator with a 16-entry table and keeps the address, offset and page widths at their defaults. Sixteen entries let the bench fill the whole table. Drawing tags from a small pool then makes many entries share one tag. This puts lowest-index selection, invalid entries with stale tags and index wrap of the full table within reach of a few hundred lookups.

// File: rtl/vpx_pkg.sv
// Shared types for the associative page translator.
// Assumes: the field select encoding is fixed by the load protocol.
package vpx_pkg;
    typedef enum logic {
        FLD_PPN = 1'b0,
        FLD_TAG = 1'b1
    } fld_e;
endpackage

// File: rtl/vpx_strobe_edge.sv
// Turns a level write strobe into a one-cycle pulse on its rising edge.
// Assumes: the strobe is synchronous to clk and returns low between writes.
module vpx_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic pulse
);
    logic strobe_q;

    // Remember last strobe level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign pulse = strobe & ~strobe_q;

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/vpx_tag_table.sv
// Entry storage: tag, physical page and valid bit per entry, with a
// parallel compare of every valid tag against the lookup tag.
// Assumes: at most one field of one entry is written per cycle.
module vpx_tag_table #(
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 22,
    parameter int PPN_W   = 14,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  vpx_pkg::fld_e                  wr_fld,
    input  logic [TAG_W-1:0]               wr_tag,
    input  logic [PPN_W-1:0]               wr_ppn,
    input  logic [TAG_W-1:0]               lookup_tag,
    output logic [ENTRIES-1:0]             match_vec,
    output logic [ENTRIES-1:0]             valid_vec,
    output logic [ENTRIES-1:0][PPN_W-1:0]  ppn_all
);
    logic [ENTRIES-1:0][TAG_W-1:0] tag_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));

        // Store one entry's fields; a tag write also validates it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[i]     <= '0;
                ppn_all[i]   <= '0;
                valid_vec[i] <= 1'b0;
            end else if (sel) begin
                if (wr_fld == vpx_pkg::FLD_TAG) begin
                    tag_q[i]     <= wr_tag;
                    valid_vec[i] <= 1'b1;
                end else begin
                    ppn_all[i]   <= wr_ppn;
                end
            end
        end

        // Compare this entry against the lookup tag.
        assign match_vec[i] = valid_vec[i] && (tag_q[i] == lookup_tag);
    end

    // R1
    reset_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (valid_vec == '0));

    // R10
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_vec) && $stable(tag_q) && $stable(ppn_all));

    // R12
    ppn_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fld == vpx_pkg::FLD_PPN) |=> $stable(valid_vec));

    // R8
    tag_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fld == vpx_pkg::FLD_TAG) |=> valid_vec[$past(wr_idx)]);
endmodule

// File: rtl/vpx_first_match.sv
// Priority encoder: picks the lowest-index set bit of the match vector.
// Assumes: the match vector is already qualified by entry valid bits.
module vpx_first_match #(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] match_vec,
    output logic               hit,
    output logic [IDX_W-1:0]   sel_idx
);
    // Scan from the top so the lowest matching index is written last.
    always_comb begin
        hit     = 1'b0;
        sel_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end

    // R6
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (match_vec[sel_idx] &&
                 ((match_vec & ~({ENTRIES{1'b1}} << sel_idx)) == '0)));

    // R5
    miss_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec == '0) |-> !hit);
endmodule

// File: rtl/vpage_xlate.sv
// Associative virtual page translator top. Registers the virtual address,
// compares its page number against all entries, and registers hit and
// {physical page, offset} one cycle later. Load mode reuses the same pins.
// Assumes: the index stays fixed across the two field writes of one entry.
module vpage_xlate #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 10,
    parameter int PPN_W   = 14,
    parameter int ENTRIES = 256,
    localparam int TAG_W  = VA_W - OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xlate_mode,
    input  logic [VA_W-1:0]  a_bus,
    input  logic [IDX_W-1:0] idx_bus,
    input  logic             field_sel,
    input  logic             wr_strobe,
    input  logic             pa_en,
    output logic             hit_out,
    output logic             hit_oe,
    output logic [PA_W-1:0]  pa_out,
    output logic             pa_oe
);
    logic                          wr_pulse;
    logic                          tbl_wr;
    logic [VA_W-1:0]               va_q;
    logic                          xl_v;
    logic [ENTRIES-1:0]            match_vec;
    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_all;
    logic                          hit_c;
    logic [IDX_W-1:0]              sel_idx;
    logic [PPN_W-1:0]              ppn_sel;
    logic                          hit_q;
    logic [PA_W-1:0]               pa_q;

    vpx_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (wr_strobe),
        .pulse  (wr_pulse)
    );

    assign tbl_wr = wr_pulse & ~xlate_mode;

    // Capture the virtual address and mark a lookup pending in translate mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q <= '0;
            xl_v <= 1'b0;
        end else begin
            xl_v <= xlate_mode;
            if (xlate_mode) va_q <= a_bus;
        end
    end

    vpx_tag_table #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .PPN_W   (PPN_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_wr),
        .wr_idx     (idx_bus),
        .wr_fld     (vpx_pkg::fld_e'(field_sel)),
        .wr_tag     (a_bus[VA_W-1:OFF_W]),
        .wr_ppn     (a_bus[PPN_W-1:0]),
        .lookup_tag (va_q[VA_W-1:OFF_W]),
        .match_vec  (match_vec),
        .valid_vec  (valid_vec),
        .ppn_all    (ppn_all)
    );

    vpx_first_match #(
        .ENTRIES (ENTRIES)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_vec (match_vec),
        .hit       (hit_c),
        .sel_idx   (sel_idx)
    );

    assign ppn_sel = hit_c ? ppn_all[sel_idx] : '0;

    // Register the lookup result when a lookup is pending; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            pa_q  <= '0;
        end else if (xl_v) begin
            hit_q <= hit_c;
            pa_q  <= {ppn_sel, va_q[OFF_W-1:0]};
        end
    end

    assign hit_out = hit_q;
    assign hit_oe  = xlate_mode;
    assign pa_oe   = xlate_mode & pa_en;
    assign pa_out  = pa_oe ? pa_q : '0;

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_v |=> pa_q[OFF_W-1:0] == $past(va_q[OFF_W-1:0]));

    // R11
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_v |=> $stable(hit_q) && $stable(pa_q));

    // R5
    empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_v && valid_vec == '0) |=> !hit_q);
endmodule

// File: tb/vpage_xlate_tb.sv
`timescale 1ns/1ps
module vpage_xlate_tb;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_mode = 1'b0;
    logic [31:0] a_bus = '0;
    logic [3:0]  idx_bus = '0;
    logic        field_sel = 1'b0;
    logic        wr_strobe = 1'b0;
    logic        pa_en = 1'b0;
    logic        hit_out, hit_oe, pa_oe;
    logic [23:0] pa_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [21:0] m_tag [NE];
    logic [13:0] m_ppn [NE];
    logic        m_val [NE];
    logic [21:0] pool  [6];

    always #4 clk = ~clk;

    vpage_xlate #(.ENTRIES(NE)) u_dut (
        .clk(clk), .rst_n(rst_n), .xlate_mode(xlate_mode), .a_bus(a_bus),
        .idx_bus(idx_bus), .field_sel(field_sel), .wr_strobe(wr_strobe),
        .pa_en(pa_en), .hit_out(hit_out), .hit_oe(hit_oe),
        .pa_out(pa_out), .pa_oe(pa_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_hit(input logic [21:0] vpn);
        logic h = 1'b0;
        for (int i = 0; i < NE; i++) if (m_val[i] && m_tag[i] == vpn) h = 1'b1;
        return h;
    endfunction

    function automatic logic [13:0] exp_ppn(input logic [21:0] vpn);
        logic [13:0] p = '0;
        for (int i = NE - 1; i >= 0; i--) if (m_val[i] && m_tag[i] == vpn) p = m_ppn[i];
        return p;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NE; i++) begin
            m_tag[i] = '0; m_ppn[i] = '0; m_val[i] = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; xlate_mode = 1'b0; wr_strobe = 1'b0; pa_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
    endtask

    // Write one field of one entry (load mode), and track it in the model.
    task automatic ld(input int idx, input bit fld, input logic [31:0] data);
        xlate_mode = 1'b0; idx_bus = 4'(idx); field_sel = fld; a_bus = data;
        wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
        @(negedge clk);
        if (fld) begin m_tag[idx] = data[31:10]; m_val[idx] = 1'b1; end
        else     m_ppn[idx] = data[13:0];
    endtask

    // Translate one address and check the registered result.
    task automatic xl(input string req, input logic [31:0] va, input bit en);
        logic [23:0] e_pa;
        xlate_mode = 1'b1; a_bus = va; pa_en = en;
        @(negedge clk);
        @(negedge clk);
        e_pa = en ? {exp_ppn(va[31:10]), va[9:0]} : 24'h0;
        chk({req, " hit"}, {31'h0, hit_out}, {31'h0, exp_hit(va[31:10])});
        chk({req, " pa"}, {8'h0, pa_out}, {8'h0, e_pa});
        chk({req, " pa_oe R7"}, {31'h0, pa_oe}, {31'h0, en});
        chk({req, " hit_oe R4"}, {31'h0, hit_oe}, 32'h1);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();
        // R1: reset state
        chk("R1 hit after reset", {31'h0, hit_out}, 32'h0);
        chk("R1 pa after reset", {8'h0, pa_out}, 32'h0);
        chk("R1 pa_oe after reset", {31'h0, pa_oe}, 32'h0);
        chk("R4 hit_oe in load", {31'h0, hit_oe}, 32'h0);

        // R12: page-only entry with a reset tag of zero must not hit page 0
        ld(15, 1'b0, 32'h0000_1234);
        xl("R12 page-only entry", {22'h0, 10'h055}, 1'b1);

        // R4 R2 R8: basic hit
        ld(5, 1'b0, 32'h0000_0abc);
        ld(5, 1'b1, {22'h12345, 10'h0});
        xl("R4 R8 basic hit", {22'h12345, 10'h3a7}, 1'b1);
        chk("R2 offset bits", {22'h0, pa_out[9:0]}, 32'h3a7);
        xl("R7 output disabled", {22'h12345, 10'h3a7}, 1'b0);

        // R6: lower index with the same tag wins
        ld(2, 1'b0, 32'h0000_0111);
        ld(2, 1'b1, {22'h12345, 10'h0});
        ld(9, 1'b0, 32'h0000_0999);
        ld(9, 1'b1, {22'h12345, 10'h0});
        xl("R6 lowest index", {22'h12345, 10'h001}, 1'b1);
        chk("R6 page 0111", {18'h0, pa_out[23:10]}, 32'h0111);

        // R3: one-cycle latency, then R5 miss
        xlate_mode = 1'b1; a_bus = {22'h3ffff, 10'h2c3}; pa_en = 1'b1;
        @(negedge clk);
        chk("R3 old result held", {31'h0, hit_out}, 32'h1);
        @(negedge clk);
        chk("R3 new result", {31'h0, hit_out}, 32'h0);
        chk("R5 miss page zero", {8'h0, pa_out}, {8'h0, 14'h0, 10'h2c3});

        // R11: result held through load mode
        xl("R11 setup hit", {22'h12345, 10'h0}, 1'b1);
        ld(2, 1'b1, {22'h00777, 10'h0});
        chk("R11 hit held in load", {31'h0, hit_out}, 32'h1);
        chk("R7 pa zero in load", {8'h0, pa_out}, 32'h0);
        ld(5, 1'b1, {22'h00888, 10'h0});
        ld(9, 1'b1, {22'h00777, 10'h0});
        chk("R11 hit still held", {31'h0, hit_out}, 32'h1);
        xl("R5 old tag gone", {22'h12345, 10'h0}, 1'b1);
        xl("R6 retagged lowest", {22'h00777, 10'h3ff}, 1'b1);

        // R9: strobe held high, bus changes are not written
        ld(3, 1'b0, 32'h0000_2222);
        xlate_mode = 1'b0; idx_bus = 4'd3; field_sel = 1'b1;
        a_bus = {22'h0aaaa, 10'h0}; wr_strobe = 1'b1;
        @(negedge clk);
        a_bus = {22'h0bbbb, 10'h0};
        @(negedge clk);
        wr_strobe = 1'b0;
        @(negedge clk);
        m_tag[3] = 22'h0aaaa; m_val[3] = 1'b1;
        xl("R9 first value written", {22'h0aaaa, 10'h010}, 1'b1);
        xl("R9 later value ignored", {22'h0bbbb, 10'h010}, 1'b1);

        // R10: strobe edge in translate mode writes nothing
        xlate_mode = 1'b1; idx_bus = 4'd4; field_sel = 1'b1;
        a_bus = {22'h0cccc, 10'h0}; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
        @(negedge clk);
        xl("R10 no write in translate", {22'h0cccc, 10'h0}, 1'b1);

        // Random fill and lookups (R4 R5 R6 R2 R7)
        do_reset();
        for (int k = 0; k < 6; k++) pool[k] = 22'($urandom);
        for (int i = 0; i < NE; i++) begin
            ld(i, 1'b0, 32'($urandom));
            if (($urandom % 4) != 0) ld(i, 1'b1, {pool[$urandom % 6], 10'h0});
        end
        for (int n = 0; n < 200; n++) begin
            logic [21:0] vpn;
            vpn = (($urandom % 5) != 0) ? pool[$urandom % 6] : 22'($urandom);
            xl("R4 R5 R6 random", {vpn, 10'($urandom)}, 1'($urandom));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule